// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block takes received Ethernet frames from a byte stream and places each one into a memory buffer chosen by a ring of descriptors. Each descriptor takes two 32-bit words in memory. The first word holds the buffer address, with two flag bits in its low end. The second word is a status word that the block fills with the frame length. When a frame begins, the block reads the current descriptor's address word. If the buffer is still held by software, the frame is thrown away and buffer-not-available is flagged. If the buffer is free, the frame bytes are packed little-endian into 32-bit words and written to the buffer. Then the status word is written, and the address word is written last with its owned flag set. After that the block moves on to the next descriptor, or goes back to the ring base when the wrap flag is set.

Software loads the ring base, sets up the descriptors in memory and enables reception. To return a buffer it clears the owned flag. It watches a three-bit status register whose bits are cleared by writing ones. The byte stream uses valid/ready. In the idle state, `in_ready` stays low while a start-of-frame byte waits for its descriptor fetch. During a frame, `in_ready` drops for at least one cycle each time a packed word (or the final partial word) goes out to memory. The data, start, end and error flags of a held byte must stay stable until it is accepted. The memory port also uses valid/ready: read data is taken in the cycle where `mem_ready` is high.

Top module: `rxr_ring_wb`

## Requirements
- R1: After reset the status register reads 000 and `mem_valid` is low.
- R2: At frame start the block reads the address word at the current descriptor pointer. Bit 0 of that word is the owned flag and bit 1 is the wrap flag. The buffer address is the word with bits 1:0 forced to zero.
- R3: Frame byte k goes to byte lane k mod 4 (lane 0 = bits 7:0) of the word at buffer + 4*(k/4). Lanes past the end of the frame in the last word are written as zero, and no word past that one is written.
- R4: The status word (descriptor pointer + 4) is written with the stored byte count in bits 10:0 and zero in all other bits. The count includes every header and CRC byte delivered.
- R5: The address word is rewritten only after the status word, with bit 0 set and the address and wrap bit unchanged. When that write is accepted, status bit 0 (frame received) is set.
- R6: After a completed frame the pointer moves forward by 8 bytes, or returns to the ring base when the wrap flag was set.
- R7: If the fetched descriptor is owned, the whole frame is consumed and dropped, nothing is written to memory, status bit 2 (buffer not available) is set, and the pointer stays put.
- R8: Bytes beyond the buffer size (default 1536) are consumed but not stored. The written length equals the buffer size, the next buffer's memory is untouched, and status bit 1 (overrun) is set along with bit 0.
- R9: A frame with `in_err` on any byte gets no status or address-word writeback, sets no status bit, and leaves the pointer in place.
- R10: Writing ones with `stat_clr_we` clears exactly the chosen status bits. A bit being set in the same cycle stays set.
- R11: A base load takes `cfg_base` with its low 6 bits forced to zero, and it also moves the descriptor pointer to that base.
- R12: When `rx_enable` is low, or when idle bytes arrive without `in_sof`, the bytes are accepted and dropped with no memory access and no status change.
- R13: Once raised, `mem_valid` stays high with address, write enable and write data unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Reception enable |
| cfg_base_we | input | 1 | Load ring base and reset pointer |
| cfg_base | input | 32 | Ring base value (low 6 bits ignored) |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr | input | 3 | Status bits to clear |
| stat | output | 3 | Status: bit0 received, bit1 overrun, bit2 no buffer |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Receive byte accepted |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error flag |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
A memory write takes effect at the clock edge where it is accepted. The frame-received and overrun bits rise one cycle after the owned-word write is accepted. Buffer-not-available rises one cycle after the descriptor read is accepted. After the last byte of a frame is accepted, at most three memory writes are still to come, even under memory stalls. The bench therefore waits a fixed budget of cycles and only then reads memory and status on a falling edge, well after every one of those edges. Write ordering is checked on every descriptor write as it happens, at the accepting edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RECV,
    ST_WDATA,
    ST_WSTAT,
    ST_WOWN,
    ST_DROP
  } rxr_state_e;

  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int STAT_W   = 3;
  localparam int STAT_REC = 0;
  localparam int STAT_OVR = 1;
  localparam int STAT_BNA = 2;
  localparam int DESC_BYTES = 8;
  localparam int STAT_WORD_OFS = 4;
endpackage

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int BUF_BYTES = 1536,
  parameter int LEN_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             push,
  input  logic [7:0]       byte_in,
  input  logic             flush,
  output logic [31:0]      word,
  output logic [LEN_W-1:0] count,
  output logic             room
);
  assign room = (count < LEN_W'(BUF_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else if (start) begin
      word  <= '0;
      count <= '0;
    end else begin
      if (flush) word <= '0;
      if (push && room) begin
        word[{count[1:0], 3'b000} +: 8] <= byte_in;
        count <= count + 1'b1;
      end
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LEN_W'(BUF_BYTES));

  assert_trunc_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !room && !start && !flush) |=> ($stable(word) && $stable(count)));
endmodule

// File: rtl/rxr_status.sv
module rxr_status
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_eff) | set;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_chk
    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[i] && !set[i]) |=> !stat[i]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> stat[i]);
  end
endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr #(
  parameter int AW = 32,
  parameter int ALIGN_BITS = 6,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] base,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] align_mask;
  assign align_mask = ~AW'((1 << ALIGN_BITS) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else if (load) begin
      base <= load_val & align_mask;
      cur  <= load_val & align_mask;
    end else if (adv) begin
      cur <= wrap ? base : cur + AW'(STEP);
    end
  end

  assert_wrap_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !load) |=> (cur == base));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !load) |=> (cur == $past(cur) + AW'(STEP)));
endmodule

// File: rtl/rxr_ring_wb.sv
module rxr_ring_wb
  import rxr_pkg::*;
#(
  parameter int AW = 32,
  parameter int BUF_BYTES = 1536,
  parameter int RING_ALIGN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              cfg_base_we,
  input  logic [AW-1:0]     cfg_base,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr,
  output logic [STAT_W-1:0] stat,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int LEN_W = $clog2(BUF_BYTES + 1);
  localparam int ALIGN_BITS = $clog2(RING_ALIGN);

  rxr_state_e state;
  logic [AW-1:0] buf_addr, data_addr, ptr_cur, ptr_base;
  logic wrap_q, err_q, trunc_q, last_q, stat_seen;

  logic in_fire, mem_fire;
  logic pk_start, pk_push, pk_flush, pk_room;
  logic [31:0] pk_word;
  logic [LEN_W-1:0] pk_count;
  logic stored, full_after, pend_after, owned_seen;
  logic [STAT_W-1:0] stat_set;

  assign in_fire  = in_valid && in_ready;
  assign mem_fire = mem_valid && mem_ready;

  always_comb begin
    case (state)
      ST_IDLE: in_ready = !rx_enable || !in_sof;
      ST_RECV: in_ready = 1'b1;
      ST_DROP: in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_cur;
    mem_wdata = '0;
    case (state)
      ST_FETCH: begin
        mem_valid = 1'b1;
      end
      ST_WDATA: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = data_addr;
        mem_wdata = pk_word;
      end
      ST_WSTAT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_cur + AW'(STAT_WORD_OFS);
        mem_wdata = 32'(pk_count);
      end
      ST_WOWN: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = 32'({buf_addr[AW-1:2], wrap_q, 1'b1});
      end
      default: ;
    endcase
  end

  assign owned_seen = mem_rdata[OWN_BIT];
  assign pk_start   = (state == ST_FETCH) && mem_fire && !owned_seen;
  assign pk_push    = (state == ST_RECV) && in_fire;
  assign pk_flush   = (state == ST_WDATA) && mem_fire;
  assign stored     = pk_push && pk_room;
  assign full_after = stored && (pk_count[1:0] == 2'd3);
  assign pend_after = (pk_count[1:0] != 2'd0) || stored;

  always_comb begin
    stat_set = '0;
    stat_set[STAT_REC] = (state == ST_WOWN) && mem_fire;
    stat_set[STAT_OVR] = (state == ST_WOWN) && mem_fire && trunc_q;
    stat_set[STAT_BNA] = (state == ST_FETCH) && mem_fire && owned_seen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      buf_addr  <= '0;
      data_addr <= '0;
      wrap_q    <= 1'b0;
      err_q     <= 1'b0;
      trunc_q   <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid && in_sof && rx_enable) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (mem_fire) begin
            if (owned_seen) begin
              state <= ST_DROP;
            end else begin
              state     <= ST_RECV;
              buf_addr  <= AW'(mem_rdata) & ~AW'(3);
              data_addr <= AW'(mem_rdata) & ~AW'(3);
              wrap_q    <= mem_rdata[WRAP_BIT];
              err_q     <= 1'b0;
              trunc_q   <= 1'b0;
              last_q    <= 1'b0;
            end
          end
        end
        ST_RECV: begin
          if (in_fire) begin
            err_q   <= err_q || in_err;
            trunc_q <= trunc_q || !pk_room;
            if (in_eof) begin
              last_q <= 1'b1;
              if (pend_after)          state <= ST_WDATA;
              else if (err_q || in_err) state <= ST_IDLE;
              else                      state <= ST_WSTAT;
            end else if (full_after) begin
              state <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (mem_fire) begin
            data_addr <= data_addr + AW'(4);
            if (!last_q)    state <= ST_RECV;
            else if (err_q) state <= ST_IDLE;
            else            state <= ST_WSTAT;
          end
        end
        ST_WSTAT: begin
          if (mem_fire) state <= ST_WOWN;
        end
        ST_WOWN: begin
          if (mem_fire) state <= ST_IDLE;
        end
        ST_DROP: begin
          if (in_fire && in_eof) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Tracks, from the memory port itself, whether this frame's status word went out.
  always_ff @(posedge clk) begin
    if (!rst_n)                 stat_seen <= 1'b0;
    else if (state == ST_IDLE)  stat_seen <= 1'b0;
    else if (mem_fire && mem_we && (mem_addr == ptr_cur + AW'(STAT_WORD_OFS)))
      stat_seen <= 1'b1;
  end

  rxr_packer #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .start(pk_start), .push(pk_push),
    .byte_in(in_data), .flush(pk_flush), .word(pk_word),
    .count(pk_count), .room(pk_room)
  );

  rxr_status u_status (
    .clk(clk), .rst_n(rst_n), .set(stat_set), .clr_we(stat_clr_we),
    .clr_mask(stat_clr), .stat(stat)
  );

  rxr_ptr #(.AW(AW), .ALIGN_BITS(ALIGN_BITS), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(cfg_base_we), .load_val(cfg_base),
    .adv(stat_set[STAT_REC]), .wrap(wrap_q), .base(ptr_base), .cur(ptr_cur)
  );

  assert_own_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && mem_we && (mem_addr == ptr_cur) && mem_wdata[OWN_BIT]) |-> stat_seen);

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cfg_base_we) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |-> !mem_valid);
endmodule

// File: tb/rxr_ring_wb_bench.sv
module rxr_ring_wb_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RING = 32'h3800;
  localparam int RING_W = 32'h3800 / 4;
  localparam int BUFSZ = 1536;
  localparam logic [31:0] FILL = 32'hA5A5A5A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0, cfg_base_we = 1'b0, stat_clr_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0] stat_clr = '0, stat;
  logic in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:4095];
  logic [4:0] lfsr = 5'h15;
  logic stall_en = 1'b0;
  logic acc_q = 1'b0;
  logic [31:0] last_wr = '0;
  int n_tests = 0, n_fail = 0, wr_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_ring_wb u_rxr_ring_wb (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cfg_base_we(cfg_base_we),
    .cfg_base(cfg_base), .stat_clr_we(stat_clr_we), .stat_clr(stat_clr), .stat(stat),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_ready = !stall_en || lfsr[0];
  assign mem_rdata = mem[mem_addr[13:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    lfsr  <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    acc_q <= in_valid && in_ready;
    if (mem_valid && mem_ready && mem_we) begin
      wr_cnt++;
      mem[mem_addr[13:2]] <= mem_wdata;
      // R5: a descriptor address word must directly follow its status word
      if (mem_addr >= RING && mem_addr < RING + 64 && mem_addr[2] == 1'b0)
        chk(last_wr == mem_addr + 4, "R5 order", last_wr, mem_addr + 4);
      last_wr <= mem_addr;
    end
  end

  function automatic logic [7:0] fb(input logic [7:0] seed, input int k);
    return seed + 8'(k * 3);
  endfunction

  function automatic logic [31:0] bufa(input int d);
    return 32'(d * BUFSZ);
  endfunction

  task automatic send_frame(input int len, input logic [7:0] seed, input bit err,
                            input bit gap, input bit nosof);
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1;
      in_data  = fb(seed, k);
      in_sof   = (k == 0) && !nosof;
      in_eof   = (k == len - 1);
      in_err   = err && (k == len - 1);
      do @(negedge clk); while (!acc_q);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
      if (gap && (k % 5 == 2)) @(negedge clk);
    end
    repeat (60) @(negedge clk);
  endtask

  task automatic clear_stat(input logic [2:0] m);
    stat_clr_we = 1'b1; stat_clr = m;
    @(negedge clk);
    stat_clr_we = 1'b0; stat_clr = '0;
    @(negedge clk);
  endtask

  task automatic check_frame(input int d, input int len, input logic [7:0] seed, input string req);
    int stored;
    int bad;
    logic [31:0] ew, aw, ba, be;
    stored = (len > BUFSZ) ? BUFSZ : len;
    bad = 0; ba = '0; be = '0;
    for (int w = 0; w < (stored + 3) / 4; w++) begin
      ew = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < stored) ew[b*8 +: 8] = fb(seed, w * 4 + b);
      aw = mem[bufa(d) / 4 + w];
      if (aw !== ew && bad == 0) begin bad = 1; ba = aw; be = ew; end
    end
    chk(bad == 0, {req, " R3 data"}, ba, be);
    chk(mem[RING_W + 2*d + 1] == 32'(stored), {req, " R4 length"}, mem[RING_W + 2*d + 1], 32'(stored));
    chk(mem[RING_W + 2*d] == (bufa(d) | 32'h1 | ((d == 7) ? 32'h2 : 32'h0)), {req, " R5 owned"},
        mem[RING_W + 2*d], bufa(d) | 32'h1 | ((d == 7) ? 32'h2 : 32'h0));
  endtask

  task automatic t_reset;
    chk(stat == 3'b000, "R1 stat", 32'(stat), 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
  endtask

  task automatic t_basic;
    send_frame(64, 8'h10, 0, 0, 0);
    check_frame(0, 64, 8'h10, "R2 R11 basic");
    chk(stat == 3'b001, "R5 rec bit", 32'(stat), 1);
    clear_stat(3'b111);
  endtask

  task automatic t_odd_stall;
    stall_en = 1'b1;
    send_frame(61, 8'h33, 0, 1, 0);
    stall_en = 1'b0;
    check_frame(1, 61, 8'h33, "R13 R12 odd stalled");
    chk(mem[bufa(1)/4 + 16] == FILL, "R3 no extra word", mem[bufa(1)/4 + 16], FILL);
    clear_stat(3'b111);
  endtask

  task automatic t_bna;
    mem[RING_W + 4] = bufa(2) | 32'h1;
    send_frame(40, 8'h55, 0, 0, 0);
    chk(stat == 3'b100, "R7 bna bit", 32'(stat), 4);
    chk(mem[bufa(2)/4] == FILL, "R7 buffer untouched", mem[bufa(2)/4], FILL);
    chk(mem[RING_W + 5] == 0, "R7 status untouched", mem[RING_W + 5], 0);
    clear_stat(3'b111);
    mem[RING_W + 4] = bufa(2);
    send_frame(40, 8'h66, 0, 0, 0);
    check_frame(2, 40, 8'h66, "R7 pointer held");
    clear_stat(3'b111);
  endtask

  task automatic t_error;
    send_frame(20, 8'h77, 1, 0, 0);
    chk(mem[RING_W + 6] == bufa(3), "R9 not owned", mem[RING_W + 6], bufa(3));
    chk(mem[RING_W + 7] == 0, "R9 no status", mem[RING_W + 7], 0);
    chk(stat == 3'b000, "R9 no stat bits", 32'(stat), 0);
    send_frame(24, 8'h88, 0, 0, 0);
    check_frame(3, 24, 8'h88, "R9 pointer held");
    clear_stat(3'b111);
  endtask

  task automatic t_overrun;
    send_frame(1540, 8'h01, 0, 0, 0);
    check_frame(4, 1540, 8'h01, "R8 truncated");
    chk(mem[bufa(5)/4] == FILL, "R8 next buffer untouched", mem[bufa(5)/4], FILL);
    chk(stat == 3'b011, "R8 ovr bit", 32'(stat), 3);
  endtask

  task automatic t_w1c;
    clear_stat(3'b001);
    chk(stat == 3'b010, "R10 partial clear", 32'(stat), 2);
    clear_stat(3'b010);
    chk(stat == 3'b000, "R10 full clear", 32'(stat), 0);
  endtask

  task automatic t_wrap;
    send_frame(16, 8'h90, 0, 0, 0);
    send_frame(16, 8'hA0, 0, 0, 0);
    send_frame(16, 8'hB0, 0, 0, 0);
    check_frame(5, 16, 8'h90, "R6 step5");
    check_frame(7, 16, 8'hB0, "R6 wrap desc");
    mem[RING_W] = bufa(0);
    send_frame(12, 8'hC0, 0, 0, 0);
    check_frame(0, 12, 8'hC0, "R6 wrapped to base");
    clear_stat(3'b111);
  endtask

  task automatic t_dropped;
    int w0;
    w0 = wr_cnt;
    rx_enable = 1'b0;
    send_frame(10, 8'hD0, 0, 0, 0);
    chk(wr_cnt == w0, "R12 disabled no writes", 32'(wr_cnt), 32'(w0));
    chk(stat == 3'b000, "R12 disabled no stat", 32'(stat), 0);
    rx_enable = 1'b1;
    send_frame(3, 8'hE0, 0, 0, 1);
    chk(wr_cnt == w0, "R12 stray no writes", 32'(wr_cnt), 32'(w0));
    chk(stat == 3'b000, "R12 stray no stat", 32'(stat), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = FILL;
    for (int d = 0; d < 8; d++) begin
      mem[RING_W + 2*d]     = bufa(d) | ((d == 7) ? 32'h2 : 32'h0);
      mem[RING_W + 2*d + 1] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_base_we = 1'b1; cfg_base = RING | 32'h17;
    @(negedge clk);
    cfg_base_we = 1'b0;
    rx_enable = 1'b1;
    @(negedge clk);
    t_basic();
    t_odd_stall();
    t_bna();
    t_error();
    t_overrun();
    t_w1c();
    t_wrap();
    t_dropped();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule